// File: doc/BRIEF.md
# ZQ Calibration Command Sequencer

This block schedules impedance calibration commands for a DDR3 memory controller that drives several chip selects. It raises a long calibration (ZQCL) to every enabled chip select, one after another, once after reset and again each time the controller leaves self refresh. During normal traffic it issues a short calibration (ZQCS) to every enabled chip select after a fixed number of completed refresh sequences. After each command it holds off all other device traffic for a programmed number of clocks.

Commands go to the main command arbiter through a request/grant pair. The request carries a chip-select index and a long/short flag and stays up until granted. A busy output spans the whole sequence, and the refresh engine and the rest of the controller stay quiet while it is high. Each wait is chosen by a 4-bit code. There are separate codes for the power-on long wait, the self-refresh-exit long wait and the short wait.

Top module: `zq_cal_seq`

## Requirements
- R1: No request is raised while `cfg_zq_en` is 0 or `cfg_mem_ddr3` is 0. If either drops while a sequence runs, the sequence is abandoned: request and busy are 0 from the next cycle.
- R2: Once both enables are high after reset, a long sequence (`zq_long`=1) is run once, timed by `cfg_init_code`.
- R3: A request holds `zq_req`, `zq_cs` and `zq_long` steady until the cycle in which `arb_grant` is 1.
- R4: If a grant arrives in cycle g, the wait occupies cycles g+1 to g+N. In cycle g+N+1 the next request is raised, or busy goes low after the last chip select.
- R5: Wait codes 7, 8, 9 and 10 select 128, 256, 512 and 1024 clocks (2 to the power of the code).
- R6: Codes below 7 are treated as 128 clocks and codes above 10 as 1024 clocks. While both enables are high, any reserved code in any of the three fields sets `cfg_err`, which stays 1 until reset.
- R7: A one-cycle `sr_exit` pulse while enabled starts a long sequence timed by `cfg_long_code`.
- R8: After 32 `refresh_done` pulses counted while idle and enabled, a short sequence (`zq_long`=0) timed by `cfg_short_code` is run. With 31 pulses nothing is issued.
- R9: The refresh count returns to zero on `sr_entry` and whenever a sequence starts. Pulses seen while busy are not counted, so a short calibration that falls due during a long sequence is dropped.
- R10: `zq_busy` is 1 from the first request of a sequence until its last wait ends, and 0 whenever no sequence is running.
- R11: Chip selects are served in ascending index order, and only those with their `cfg_cs_en` bit set are served. A sequence that is due while no chip select is enabled is discarded without any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_zq_en | input | 1 | Calibration enable |
| cfg_mem_ddr3 | input | 1 | Memory type is DDR3 |
| cfg_cs_en | input | NUM_CS | Enabled chip selects |
| cfg_init_code | input | 4 | Power-on long wait code |
| cfg_long_code | input | 4 | Self-refresh-exit long wait code |
| cfg_short_code | input | 4 | Short wait code |
| sr_entry | input | 1 | One-cycle pulse on self-refresh entry |
| sr_exit | input | 1 | One-cycle pulse on self-refresh exit |
| refresh_done | input | 1 | One-cycle pulse per completed refresh sequence |
| arb_grant | input | 1 | Arbiter accepts the current request |
| zq_req | output | 1 | Calibration command request |
| zq_long | output | 1 | 1 = long calibration, 0 = short |
| zq_cs | output | CS_IDX_W | Chip-select index of the request |
| zq_busy | output | 1 | Sequence in progress, other traffic blocked |
| cfg_err | output | 1 | Sticky reserved-code flag |

## Verification
The bench drives inputs and samples outputs on falling edges. It counts falling edges from the one where a grant is driven. For a wait of N clocks, the next request or the drop of busy must first appear at count N+1, one cycle for the grant register plus N wait cycles. A self-refresh exit or the 32nd refresh pulse produces its request within a few cycles. The bench therefore waits for that request with a bound rather than at a fixed cycle. When it checks that nothing is issued, it watches the request for a span well beyond that latency. A reserved code raises the error flag one cycle after it is applied. The flag is read after each wait has finished.

// File: rtl/zqc_pkg.sv
package zqc_pkg;

    localparam int CODE_W   = 4;
    localparam int MIN_CODE = 7;
    localparam int MAX_CODE = 10;
    localparam int WAIT_W   = MAX_CODE + 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } zqc_state_e;

    typedef struct packed {
        logic              is_long;
        logic [CODE_W-1:0] code;
    } zqc_seq_t;

    function automatic logic code_reserved(input logic [CODE_W-1:0] c);
        return (int'(c) < MIN_CODE) || (int'(c) > MAX_CODE);
    endfunction

    // Clamp to the legal range, then the code is the log2 of the wait.
    function automatic logic [WAIT_W-1:0] code_to_clocks(input logic [CODE_W-1:0] c);
        int k;
        logic [WAIT_W-1:0] one;
        k = int'(c);
        if (k < MIN_CODE) k = MIN_CODE;
        if (k > MAX_CODE) k = MAX_CODE;
        one = WAIT_W'(1);
        return one << k;
    endfunction

endpackage

// File: rtl/zqc_cs_pick.sv
module zqc_cs_pick #(
    parameter int NUM_CS = 4,
    parameter int IDX_W  = 2
) (
    input  logic [NUM_CS-1:0] mask,
    output logic [IDX_W-1:0]  idx,
    output logic              any
);
    always_comb begin
        idx = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
        any = |mask;
    end
endmodule

// File: rtl/zqc_wait_timer.sv
module zqc_wait_timer
    import zqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              expired
);
    logic [WAIT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/zqc_ref_count.sv
module zqc_ref_count #(
    parameter int LIMIT = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic due
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    logic [CNT_W-1:0] cnt;

    assign due = (cnt == CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr)       cnt <= '0;
        else if (inc && !due) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/zq_cal_seq.sv
module zq_cal_seq
    import zqc_pkg::*;
#(
    parameter int NUM_CS         = 4,
    parameter int REFS_PER_SHORT = 32,
    localparam int CS_IDX_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_zq_en,
    input  logic                cfg_mem_ddr3,
    input  logic [NUM_CS-1:0]   cfg_cs_en,
    input  logic [CODE_W-1:0]   cfg_init_code,
    input  logic [CODE_W-1:0]   cfg_long_code,
    input  logic [CODE_W-1:0]   cfg_short_code,
    input  logic                sr_entry,
    input  logic                sr_exit,
    input  logic                refresh_done,
    input  logic                arb_grant,
    output logic                zq_req,
    output logic                zq_long,
    output logic [CS_IDX_W-1:0] zq_cs,
    output logic                zq_busy,
    output logic                cfg_err
);
    zqc_state_e        state;
    zqc_seq_t          seq;
    logic [NUM_CS-1:0] rem_mask;
    logic [NUM_CS-1:0] rem_next;
    logic              init_pend, long_pend;
    logic              eff_en, idle, long_go, short_go, launch;
    logic              ref_due, ref_clr, ref_inc;
    logic              wait_expired, wait_load;
    logic              pick_any;
    logic [CS_IDX_W-1:0] cur_idx;

    assign eff_en   = cfg_zq_en & cfg_mem_ddr3;
    assign idle     = (state == ST_IDLE);
    assign long_go  = idle & eff_en & (init_pend | long_pend);
    assign short_go = idle & eff_en & ref_due & ~long_go;
    assign launch   = long_go | short_go;
    assign ref_clr  = sr_entry | launch;
    assign ref_inc  = refresh_done & idle & eff_en;
    assign wait_load = (state == ST_REQ) & arb_grant & eff_en;

    zqc_cs_pick #(.NUM_CS(NUM_CS), .IDX_W(CS_IDX_W)) u_pick (
        .mask (rem_mask),
        .idx  (cur_idx),
        .any  (pick_any)
    );

    zqc_wait_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (code_to_clocks(seq.code) - 1'b1),
        .expired  (wait_expired)
    );

    zqc_ref_count #(.LIMIT(REFS_PER_SHORT)) u_refs (
        .clk (clk),
        .rst (rst),
        .clr (ref_clr),
        .inc (ref_inc),
        .due (ref_due)
    );

    assign rem_next = rem_mask & ~(NUM_CS'(1) << cur_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            seq       <= '0;
            rem_mask  <= '0;
            init_pend <= 1'b1;
            long_pend <= 1'b0;
        end else if (!eff_en) begin
            state     <= ST_IDLE;
            long_pend <= 1'b0;
        end else begin
            if (sr_exit) long_pend <= 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (launch) begin
                        if (long_go) begin
                            init_pend <= 1'b0;
                            long_pend <= sr_exit;
                            seq.is_long <= 1'b1;
                            seq.code    <= init_pend ? cfg_init_code : cfg_long_code;
                        end else begin
                            seq.is_long <= 1'b0;
                            seq.code    <= cfg_short_code;
                        end
                        rem_mask <= cfg_cs_en;
                        if (|cfg_cs_en) state <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    if (arb_grant) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (wait_expired) begin
                        rem_mask <= rem_next;
                        state    <= (|rem_next) ? ST_REQ : ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_err <= 1'b0;
        else if (eff_en && (code_reserved(cfg_init_code) ||
                            code_reserved(cfg_long_code) ||
                            code_reserved(cfg_short_code)))
            cfg_err <= 1'b1;
    end

    assign zq_req  = (state == ST_REQ);
    assign zq_long = seq.is_long;
    assign zq_cs   = cur_idx;
    assign zq_busy = !idle;

    assert_off_no_req_R1: assert property (@(posedge clk) disable iff (rst)
        !eff_en |=> !zq_req);

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (zq_req && !arb_grant && eff_en) |=>
            (zq_req && $stable(zq_cs) && $stable(zq_long)));

    assert_req_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
        zq_req |-> zq_busy);

    assert_busy_ends_after_wait_R4: assert property (@(posedge clk) disable iff (rst)
        ($fell(zq_busy) && $past(eff_en)) |-> !$past(zq_req));

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    assert_req_cs_enabled_R11: assert property (@(posedge clk) disable iff (rst)
        (zq_req && $stable(cfg_cs_en) && $past(idle)) |-> cfg_cs_en[zq_cs]);

endmodule

// File: tb/zq_cal_seq_tb.sv
module zq_cal_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NCS = 4;
    localparam int WATCHDOG = 200000;

    localparam int NVEC = 8;
    localparam int VCODE [NVEC] = '{7, 8, 9, 10, 0, 6, 11, 15};
    localparam int VCLKS [NVEC] = '{128, 256, 512, 1024, 128, 128, 1024, 1024};
    localparam int VERR  [NVEC] = '{0, 0, 0, 0, 1, 1, 1, 1};

    logic clk = 0;
    logic rst;
    logic cfg_zq_en, cfg_mem_ddr3;
    logic [NCS-1:0] cfg_cs_en;
    logic [3:0] cfg_init_code, cfg_long_code, cfg_short_code;
    logic sr_entry, sr_exit, refresh_done, arb_grant;
    logic zq_req, zq_long, zq_busy, cfg_err;
    logic [1:0] zq_cs;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zq_cal_seq #(.NUM_CS(NCS), .REFS_PER_SHORT(32)) u_dut (
        .clk(clk), .rst(rst), .cfg_zq_en(cfg_zq_en), .cfg_mem_ddr3(cfg_mem_ddr3),
        .cfg_cs_en(cfg_cs_en), .cfg_init_code(cfg_init_code),
        .cfg_long_code(cfg_long_code), .cfg_short_code(cfg_short_code),
        .sr_entry(sr_entry), .sr_exit(sr_exit), .refresh_done(refresh_done),
        .arb_grant(arb_grant), .zq_req(zq_req), .zq_long(zq_long),
        .zq_cs(zq_cs), .zq_busy(zq_busy), .cfg_err(cfg_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count request cycles over a window; expected zero when nothing is due.
    task automatic quiet(input int n, input string tag);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (zq_req) seen++;
        end
        chk(tag, seen, 0);
    endtask

    task automatic pulse_refresh(input int n);
        for (int i = 0; i < n; i++) begin
            refresh_done = 1; @(negedge clk); refresh_done = 0; @(negedge clk);
        end
    endtask

    task automatic pulse_sr_exit();
        sr_exit = 1; @(negedge clk); sr_exit = 0;
    endtask

    // Wait for a request, check it, optionally hold off the grant, grant,
    // then count cycles until the next request or busy low (expect N+1).
    task automatic serve(input int exp_cs, input int exp_long, input int n,
                         input int hold, input string tag);
        int t = 0;
        int cnt = 0;
        while (!zq_req && t < 3000) begin @(negedge clk); t++; end
        chk({tag, " request seen"}, int'(zq_req), 1);
        chk({tag, " cs"}, int'(zq_cs), exp_cs);
        chk({tag, " long flag"}, int'(zq_long), exp_long);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R3 request held", int'(zq_req), 1);
            chk("R3 cs held", int'(zq_cs), exp_cs);
        end
        arb_grant = 1;
        @(negedge clk);
        arb_grant = 0;
        cnt = 1;
        while (zq_busy && !zq_req && cnt < 1100) begin @(negedge clk); cnt++; end
        chk({tag, " R4 R5 wait cycles"}, cnt, n + 1);
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < WATCHDOG) begin @(posedge clk); wd++; end
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog actual=%0d expected=<%0d", wd, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; cfg_zq_en = 0; cfg_mem_ddr3 = 0; cfg_cs_en = 4'b1011;
        cfg_init_code = 4'd7; cfg_long_code = 4'd8; cfg_short_code = 4'd8;
        sr_entry = 0; sr_exit = 0; refresh_done = 0; arb_grant = 0;
        cyc(3);
        rst = 0;
        @(negedge clk);
        chk("reset req", int'(zq_req), 0);
        chk("reset busy", int'(zq_busy), 0);
        chk("reset err", int'(cfg_err), 0);

        // R1: disabled, then enabled without the DDR3 type
        quiet(40, "R1 enable clear");
        cfg_zq_en = 1;
        quiet(40, "R1 not DDR3");

        // R2 R11: power-on long sequence over cs 0,1,3 in order
        cfg_mem_ddr3 = 1;
        serve(0, 1, 128, 5, "R2 cs0");
        serve(1, 1, 128, 0, "R2 R11 cs1");
        serve(3, 1, 128, 0, "R2 R11 cs3");
        chk("R10 busy low after last wait", int'(zq_busy), 0);
        quiet(20, "R2 runs once");

        // R5 R6 R7: code table walked via self-refresh exits on cs 2
        cfg_cs_en = 4'b0100;
        for (int v = 0; v < NVEC; v++) begin
            cfg_long_code = 4'(VCODE[v]);
            pulse_sr_exit();
            serve(2, 1, VCLKS[v], 0, "R7 R5 R6 vector");
            chk("R6 error flag", int'(cfg_err), VERR[v]);
        end
        cfg_long_code = 4'd8;
        cyc(5);
        chk("R6 error sticky", int'(cfg_err), 1);

        // R8: short calibration after 32 refreshes
        cfg_cs_en = 4'b0011;
        pulse_refresh(31);
        quiet(20, "R8 31 refreshes");
        pulse_refresh(1);
        serve(0, 0, 256, 0, "R8 short cs0");
        serve(1, 0, 256, 0, "R8 short cs1");
        chk("R10 busy low after short", int'(zq_busy), 0);

        // R9: self-refresh entry clears the count
        pulse_refresh(20);
        sr_entry = 1; @(negedge clk); sr_entry = 0;
        pulse_refresh(20);
        quiet(20, "R9 cleared by sr entry");
        pulse_refresh(12);
        serve(0, 0, 256, 0, "R9 short after 32 new");
        serve(1, 0, 256, 0, "R9 short cs1");

        // R9: due short dropped when a long sequence starts
        pulse_refresh(31);
        pulse_sr_exit();
        serve(0, 1, 256, 0, "R9 long cs0");
        serve(1, 1, 256, 0, "R9 long cs1");
        pulse_refresh(1);
        quiet(20, "R9 short skipped");
        sr_entry = 1; @(negedge clk); sr_entry = 0;

        // R11: nothing enabled, pending sequence discarded
        cfg_cs_en = 4'b0000;
        pulse_sr_exit();
        quiet(20, "R11 no cs enabled");
        cfg_cs_en = 4'b0001;
        quiet(20, "R11 pending discarded");

        // R1: disable during a pending request aborts it
        pulse_sr_exit();
        cyc(3);
        chk("R1 request before abort", int'(zq_req), 1);
        cfg_zq_en = 0;
        @(negedge clk);
        chk("R1 abort req", int'(zq_req), 0);
        chk("R1 abort busy", int'(zq_busy), 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule